// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a synchronous keypad lock. A user enters three 4-bit digits one after another. Each digit is presented on a small data bus and qualified by a one-cycle strobe. The lock opens only when the first, second and third digits equal the first, second and third stored codes. Any wrong digit sends it into a trap state, where it stays closed. Both the trap and the open state are left only through the clear input or the asynchronous reset.

The three stored codes sit in loadable registers. A 2-bit load field selects which register, if any, takes the value on the digit bus at the next clock edge. After reset the codes are 3, 4 and 2.

The controller state is held in four bits:
- The top bit is the open output.
- The lower three bits form the one-hot select of the code multiplexer that feeds the comparator.

Top module: `combo_lock_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `lock_state` is 4'b0001 (first-digit state) and `lock_open` is 0. The codes after reset are 3, 4, 2 in entry order.
- R2: In the first-, second- or third-digit state (4'b0001, 4'b0010, 4'b0100), a cycle with `dig_stb` low and `lock_clr` low leaves `lock_state` unchanged, whatever `dig_in` carries.
- R3: A strobed digit equal to the code for the current position advances the state on the next edge: 4'b0001 to 4'b0010 to 4'b0100 to 4'b1000 (open). `lock_state` is always one of the five legal encodings.
- R4: A strobed digit that differs from the code for the current position moves the state to 4'b0000 (error) on the next edge.
- R5: The error state holds with `lock_open` low until `lock_clr`, even when correct digits are strobed.
- R6: The open state holds with `lock_open` high until `lock_clr`. Further strobes, correct or wrong, have no effect.
- R7: `lock_clr` high returns the state to 4'b0001 on the next edge from any state. It takes priority over a strobe, and the stored codes are left unchanged.
- R8: `code_ld` = 2'b01, 2'b10 and 2'b11 load `dig_in` into code 1, code 2 and code 3 at the next edge; 2'b00 loads nothing. A load never changes `lock_state`.
- R9: `lock_open` always equals bit 3 of `lock_state`.
- R10: When a load and a strobe fall in the same cycle, the comparison uses the code value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lock_clr | input | 1 | Synchronous clear back to the first-digit state |
| dig_in | input | 4 | Entered digit, also the data for code loads |
| dig_stb | input | 1 | One-cycle qualifier for `dig_in` as an entered digit |
| code_ld | input | 2 | Code register load select; 00 means no load |
| lock_open | output | 1 | High while the lock is open |
| lock_state | output | 4 | Controller state encoding |

## Verification
The bench drives the following corner cases:
- **Wrong digit in each position.** A design that compared against the wrong code slot would open or trap on the wrong entry.
- **Correct digits strobed after a trap.** A design whose error state leaked would reopen the lock.
- **Digits presented without a strobe.** A design that did not gate on the strobe would advance or trap spuriously.
- **Clear and strobe in the same cycle.** A design that lost the priority of clear would not return to the first-digit state.
- **Load and strobe on the same digit in the same cycle.** A design that compared against the newly loaded code would unlock where it should trap.

Long random runs with reloaded codes check that loads never disturb the state.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned NUM_CODES = 3;
  localparam int unsigned ST_W      = NUM_CODES + 1;

  typedef logic [ST_W-1:0] lk_state_t;

  // One-hot position states; the low bits double as the code select.
  localparam lk_state_t ST_D1   = 4'b0001;
  localparam lk_state_t ST_D2   = 4'b0010;
  localparam lk_state_t ST_D3   = 4'b0100;
  localparam lk_state_t ST_OPEN = 4'b1000;
  localparam lk_state_t ST_ERR  = 4'b0000;

  function automatic logic st_legal(lk_state_t s);
    return (s == ST_D1) || (s == ST_D2) || (s == ST_D3) ||
           (s == ST_OPEN) || (s == ST_ERR);
  endfunction
endpackage

// File: rtl/lock_code_bank.sv
module lock_code_bank #(
  parameter int unsigned DIG_W = 4,
  parameter logic [DIG_W-1:0] RST_C1 = 4'd3,
  parameter logic [DIG_W-1:0] RST_C2 = 4'd4,
  parameter logic [DIG_W-1:0] RST_C3 = 4'd2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             ld_sel,
  input  logic [DIG_W-1:0]                       din,
  output logic [lock_pkg::NUM_CODES*DIG_W-1:0]   codes_flat
);
  import lock_pkg::*;

  localparam logic [DIG_W-1:0] RST_V [NUM_CODES] = '{RST_C1, RST_C2, RST_C3};

  logic [NUM_CODES-1:0] ld_en;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    logic [DIG_W-1:0] code_q;

    // Decoder: field value g+1 targets register g, zero loads nothing.
    assign ld_en[g] = (ld_sel == 2'(g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= RST_V[g];
      end else if (ld_en[g]) begin
        code_q <= din;
      end
    end

    assign codes_flat[g*DIG_W +: DIG_W] = code_q;
  end
endmodule

// File: rtl/lock_sel_cmp.sv
module lock_sel_cmp #(
  parameter int unsigned DIG_W = 4
) (
  input  logic [lock_pkg::NUM_CODES*DIG_W-1:0] codes_flat,
  input  logic [lock_pkg::NUM_CODES-1:0]       sel_oh,
  input  logic [DIG_W-1:0]                     din,
  output logic                                 match
);
  import lock_pkg::*;

  logic [DIG_W-1:0] picked;

  // AND-OR multiplexer driven by a one-hot select.
  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_CODES; i++) begin
      picked = picked | ({DIG_W{sel_oh[i]}} & codes_flat[i*DIG_W +: DIG_W]);
    end
  end

  assign match = (picked == din);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                stb,
  input  logic                match,
  output lock_pkg::lk_state_t state_q
);
  import lock_pkg::*;

  lk_state_t state_d;
  logic      in_entry;
  logic      upd_en;

  assign in_entry = (state_q == ST_D1) || (state_q == ST_D2) || (state_q == ST_D3);

  // The register only moves on clear, a strobed entry, or a corrupted pattern.
  assign upd_en = clr || (stb && in_entry) || !st_legal(state_q);

  always_comb begin
    state_d = state_q;
    if (clr) begin
      state_d = ST_D1;
    end else begin
      case (state_q)
        ST_D1:   if (stb) state_d = match ? ST_D2   : ST_ERR;
        ST_D2:   if (stb) state_d = match ? ST_D3   : ST_ERR;
        ST_D3:   if (stb) state_d = match ? ST_OPEN : ST_ERR;
        ST_OPEN: state_d = ST_OPEN;
        ST_ERR:  state_d = ST_ERR;
        default: state_d = ST_ERR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_D1;
    end else if (upd_en) begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/combo_lock_top.sv
module combo_lock_top #(
  parameter int unsigned DIG_W = 4,
  parameter logic [DIG_W-1:0] RST_C1 = 4'd3,
  parameter logic [DIG_W-1:0] RST_C2 = 4'd4,
  parameter logic [DIG_W-1:0] RST_C3 = 4'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_clr,
  input  logic [DIG_W-1:0] dig_in,
  input  logic             dig_stb,
  input  logic [1:0]       code_ld,
  output logic             lock_open,
  output logic [3:0]       lock_state
);
  import lock_pkg::*;

  logic [NUM_CODES*DIG_W-1:0] codes_flat;
  lk_state_t                  st;
  logic                       match;

  lock_code_bank #(
    .DIG_W (DIG_W),
    .RST_C1(RST_C1),
    .RST_C2(RST_C2),
    .RST_C3(RST_C3)
  ) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_sel    (code_ld),
    .din       (dig_in),
    .codes_flat(codes_flat)
  );

  lock_sel_cmp #(.DIG_W(DIG_W)) cmp_i (
    .codes_flat(codes_flat),
    .sel_oh    (st[NUM_CODES-1:0]),
    .din       (dig_in),
    .match     (match)
  );

  lock_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (lock_clr),
    .stb    (dig_stb),
    .match  (match),
    .state_q(st)
  );

  assign lock_open  = st[NUM_CODES];
  assign lock_state = st;
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       stb,
  input logic       opn,
  input logic [3:0] st
);
  import lock_pkg::*;

  // R9
  open_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opn == st[3]);

  // R3
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !clr && (st == ST_D1 || st == ST_D2 || st == ST_D3)) |=> $stable(st));

  // R5
  err_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERR && !clr) |=> (st == ST_ERR));

  // R6
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OPEN && !clr) |=> (st == ST_OPEN));

  // R7
  clr_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st == ST_D1));
endmodule

bind combo_lock_top combo_lock_chk chk_i (
  .clk  (clk),
  .rst_n(rst_n),
  .clr  (lock_clr),
  .stb  (dig_stb),
  .opn  (lock_open),
  .st   (lock_state)
);

// File: tb/combo_lock_top_tb_top.sv
module combo_lock_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lock_clr;
  logic [3:0] dig_in;
  logic       dig_stb;
  logic [1:0] code_ld;
  logic       lock_open;
  logic [3:0] lock_state;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0] m_st;
  logic [3:0] m_code [3];

  always #5 clk = ~clk;

  combo_lock_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_clr  (lock_clr),
    .dig_in    (dig_in),
    .dig_stb   (dig_stb),
    .code_ld   (code_ld),
    .lock_open (lock_open),
    .lock_state(lock_state)
  );

  function automatic int pos_of(logic [3:0] s);
    case (s)
      4'b0001: return 0;
      4'b0010: return 1;
      4'b0100: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [3:0] model_next(logic [3:0] s, logic c, logic v, logic [3:0] d);
    int p;
    if (c) return 4'b0001;
    p = pos_of(s);
    if (p < 0 || !v) return s;
    if (d != m_code[p]) return 4'b0000;
    return (p == 2) ? 4'b1000 : (s << 1);
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (lock_state !== m_st || lock_open !== m_st[3]) begin
      n_fail++;
      $display("FAIL %s: state=%b open=%b expected state=%b open=%b",
               tag, lock_state, lock_open, m_st, m_st[3]);
    end
  endtask

  // Drive just after a falling edge, check at the next falling edge.
  task automatic step(logic c, logic v, logic [3:0] d, logic [1:0] l, string tag);
    lock_clr = c; dig_stb = v; dig_in = d; code_ld = l;
    m_st = model_next(m_st, c, v, d);
    if (l != 2'b00) m_code[l - 1] = d;  // load after compare (R10)
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; lock_clr = 0; dig_stb = 0; dig_in = 0; code_ld = 0;
    m_st = 4'b0001;
    m_code[0] = 4'd3; m_code[1] = 4'd4; m_code[2] = 4'd2;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // Default combination opens
    step(0, 0, 4'd3, 2'b00, "R2 no strobe");
    step(0, 1, 4'd3, 2'b00, "R1 R3 digit1");
    step(0, 0, 4'd9, 2'b00, "R2 hold d2");
    step(0, 1, 4'd4, 2'b00, "R3 digit2");
    step(0, 1, 4'd2, 2'b00, "R3 R9 open");
    step(0, 1, 4'd7, 2'b00, "R6 wrong ignored");
    step(0, 1, 4'd3, 2'b00, "R6 hold");
    step(1, 1, 4'd5, 2'b00, "R7 clr over strobe");

    // Wrong digit in each position
    step(0, 1, 4'd8, 2'b00, "R4 wrong d1");
    step(0, 1, 4'd3, 2'b00, "R5 trap");
    step(0, 1, 4'd4, 2'b00, "R5 trap");
    step(0, 1, 4'd2, 2'b00, "R5 trap closed");
    step(1, 0, 4'd0, 2'b00, "R7 clr from err");
    step(0, 1, 4'd3, 2'b00, "R3 d1");
    step(0, 1, 4'd1, 2'b00, "R4 wrong d2");
    step(1, 0, 4'd0, 2'b00, "R7");
    step(0, 1, 4'd3, 2'b00, "R3");
    step(0, 1, 4'd4, 2'b00, "R3");
    step(0, 1, 4'd15, 2'b00, "R4 wrong d3");
    step(1, 0, 4'd0, 2'b00, "R7");

    // Reload codes mid-entry
    step(0, 1, 4'd3, 2'b00, "R3");
    step(0, 0, 4'd9, 2'b01, "R8 load c1 no move");
    step(0, 0, 4'd0, 2'b10, "R8 load c2");
    step(0, 0, 4'd15, 2'b11, "R8 load c3");
    step(0, 0, 4'd6, 2'b00, "R8 none");
    step(0, 1, 4'd0, 2'b00, "R8 new c2");
    step(0, 1, 4'd15, 2'b00, "R8 new c3 open");
    step(1, 0, 4'd0, 2'b00, "R7 codes kept");
    step(0, 1, 4'd9, 2'b00, "R7 R8 c1 kept");
    step(1, 0, 4'd0, 2'b00, "R7");

    // Same-cycle load and strobe
    step(0, 1, 4'd5, 2'b01, "R10 old code used");
    step(1, 0, 4'd0, 2'b00, "R7");
    step(0, 1, 4'd5, 2'b00, "R10 new code later");
    step(1, 0, 4'd0, 2'b00, "R7");

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic       c, v;
      logic [3:0] d;
      logic [1:0] l;
      int         p;
      c = ($urandom_range(0, 24) == 0);
      v = $urandom_range(0, 1);
      p = pos_of(m_st);
      if (v && p >= 0 && $urandom_range(0, 9) < 8) d = m_code[p];
      else d = 4'($urandom_range(0, 15));
      l = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      step(c, v, d, l, "R3/R4/R8 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule